// File: doc/BRIEF.md
# Register Write Command Stream Executor

This block walks a buffer of 32-bit command words, already fetched from memory, and turns it into register writes on a simple valid/ready output bus. Each command opens with a two-word header. One kind of command, the target select, picks which of ten hardware targets receive later writes. The other commands write registers inside every selected target: one single write, two burst forms (address stepping or address fixed), and a lookup-table form whose address can either hold or step and fold back inside a short window.

The executor checks the order of commands and their fields. When a buffer is malformed it raises an error flag and throws away the rest of that buffer. Each buffer is bounded by a last-word marker on the input, and the target selection lives only until the end of the buffer that set it. Target base addresses come from two parameters, a base and a stride. The write address is that target's base plus the 20-bit byte offset carried in the command.

Top module: `regdma_cmd_exec`

## Requirements
- R1: A header whose first word equals 0x180AC060 is a target select. Its second word is a mask: bits 3:0 select pipes 0-3 (targets 0-3), bit 4 the pipe gamma stage (target 4), bits 20:17 processors 0-3 (targets 5-8) and bit 21 the processor gamma stage (target 9). All other mask bits are ignored.
- R2: Every register write is issued once for each selected target, in ascending target number. The address is TGT_BASE + target*TGT_STRIDE + offset, where the offset is bits 19:0 of the first header word.
- R3: A first header word with bits 31:28 = 0001 and bits 27:20 = 0 is a single write. Its second word is the data.
- R4: Bits 31:28 = 0100 is a stepping burst. Bits 13:0 of the second word give the number of payload words that follow, and the offset rises by 4 for each word.
- R5: Bits 31:28 = 0011 is a fixed burst. Its word count is coded as in R4, and every payload word goes to the same offset.
- R6: Bits 31:28 = 0101 is a table write. In its second word, bit 31 = 1 holds the offset, bits 19:16 give a window of 2 to 15 words and bits 13:0 give the word count. With bit 31 = 0 the offset steps by 4 and returns to the header offset after every window words. A window outside 2..15 is an error.
- R7: A burst or table write with a word count of 0 issues no writes, and the next word is taken as a new header.
- R8: A write command in a buffer that has not yet had a valid target select is an error. A selection never carries over into the next buffer.
- R9: A target select whose mask selects no target, or that sets pipe bits (3:0) together with processor bits (20:17), is an error.
- R10: Any other header code is an error: a code not listed above, or a nonzero bits 27:20. So is a write offset whose bits 1:0 are not zero.
- R11: A buffer whose last word ends inside a header, or before a burst's payload is complete, is an error. The payload word that carries the early end marker is not written.
- R12: After an error no further writes come from that buffer, and its remaining words are consumed up to the last-word marker. err_o rises in the cycle after the offending word is accepted and stays high until the first word of the next buffer is accepted.
- R13: While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_data hold their values.
- R14: No input word is accepted while a write is pending (in_ready is low whenever wr_valid is high). After reset in_ready is 1, and wr_valid and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word available |
| in_ready | output | 1 | Command word taken this cycle when valid |
| in_data | input | 32 | Command stream word |
| in_last | input | 1 | Marks the final word of a buffer |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Write accepted by the bus |
| wr_addr | output | ADDR_W | Absolute byte address of the write |
| wr_data | output | 32 | Write data |
| err_o | output | 1 | Malformed buffer seen, sticky until next buffer starts |

## Verification
The bench builds the block with ADDR_W = 28, TGT_BASE = 0x0800000 and TGT_STRIDE = 0x0180000. A stride that is not a power of two selects the multiplier form of the target base logic, and the narrower address still holds all ten 1 MiB windows. Spreading targets apart by a non-binary step means that a wrong target index or a wrong fan-out order changes the expected addresses, rather than landing on an address that aliases. One scenario holds wr_ready low at pseudo-random times during a fan-out burst, which exercises the hold rule while payload words wait.

// File: rtl/regdma_pkg.sv
package regdma_pkg;

   localparam int WORD_W  = 32;
   localparam int OFF_W   = 20;
   localparam int CNT_W   = 14;
   localparam int WIN_W   = 4;
   localparam int NUM_TGT = 10;
   localparam int TIDX_W  = $clog2(NUM_TGT);

   localparam logic [WORD_W-1:0] SEL_HDR = 32'h180A_C060;

   localparam logic [3:0] OPC_SINGLE = 4'b0001;
   localparam logic [3:0] OPC_STEP   = 4'b0100;
   localparam logic [3:0] OPC_FIXED  = 4'b0011;
   localparam logic [3:0] OPC_TABLE  = 4'b0101;

   typedef enum logic [2:0] {
      K_SELECT, K_SINGLE, K_STEP, K_FIXED, K_TABLE, K_BAD
   } cmd_kind_e;

   typedef enum logic [1:0] {
      AM_HOLD, AM_STEP, AM_FOLD
   } addr_mode_e;

   typedef enum logic [2:0] {
      S_HDR0, S_HDR1, S_DATA, S_EMIT, S_DROP
   } exec_state_e;

   // Compact the sparse select mask into one bit per target, target order.
   function automatic logic [NUM_TGT-1:0] pack_mask(input logic [WORD_W-1:0] m);
      return {m[21], m[20:17], m[4], m[3:0]};
   endfunction

endpackage

// File: rtl/regdma_hdr_dec.sv
module regdma_hdr_dec
   import regdma_pkg::*;
(
   input  logic [WORD_W-1:0]  word,
   // first-word view
   output cmd_kind_e          kind,
   output logic [OFF_W-1:0]   offset,
   output logic               off_misaligned,
   // second-word view
   output logic [NUM_TGT-1:0] tgt_mask,
   output logic               mask_empty,
   output logic               mask_mixed,
   output logic [CNT_W-1:0]   count,
   output logic [WIN_W-1:0]   window,
   output logic               window_bad,
   output logic               hold_addr
);

   always_comb begin
      if (word == SEL_HDR) begin
         kind = K_SELECT;
      end else if (word[27:20] != 8'h00) begin
         kind = K_BAD;
      end else begin
         unique case (word[31:28])
            OPC_SINGLE: kind = K_SINGLE;
            OPC_STEP:   kind = K_STEP;
            OPC_FIXED:  kind = K_FIXED;
            OPC_TABLE:  kind = K_TABLE;
            default:    kind = K_BAD;
         endcase
      end
   end

   assign offset         = word[OFF_W-1:0];
   assign off_misaligned = |word[1:0];

   assign tgt_mask   = pack_mask(word);
   assign mask_empty = (tgt_mask == '0);
   assign mask_mixed = (|word[3:0]) && (|word[20:17]);

   assign count      = word[CNT_W-1:0];
   assign window     = word[16 +: WIN_W];
   assign window_bad = (word[16 +: WIN_W] < WIN_W'(2));
   assign hold_addr  = word[31];

endmodule

// File: rtl/regdma_tgt_walk.sv
module regdma_tgt_walk #(
   parameter int NT  = 10,
   parameter int IW  = $clog2(NT)
) (
   input  logic [NT-1:0] mask,
   input  logic [IW-1:0] cur,
   output logic [IW-1:0] first_idx,
   output logic [IW-1:0] next_idx,
   output logic          has_next
);

   logic [NT-1:0] above;

   for (genvar g = 0; g < NT; g++) begin : g_above
      assign above[g] = mask[g] && (IW'(g) > cur);
   end

   always_comb begin
      first_idx = '0;
      next_idx  = '0;
      for (int i = NT - 1; i >= 0; i--) begin
         if (mask[i])  first_idx = IW'(i);
         if (above[i]) next_idx  = IW'(i);
      end
   end

   assign has_next = |above;

endmodule

// File: rtl/regdma_addr_seq.sv
module regdma_addr_seq
   import regdma_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [OFF_W-1:0]  ld_off,
   input  addr_mode_e        ld_mode,
   input  logic [WIN_W-1:0]  ld_win,
   input  logic [CNT_W-1:0]  ld_cnt,
   input  logic              step,
   output logic [OFF_W-1:0]  cur_off,
   output logic [CNT_W-1:0]  words_left
);

   logic [OFF_W-1:0] base_q;
   addr_mode_e       mode_q;
   logic [WIN_W-1:0] win_q;
   logic [WIN_W-1:0] pos_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_off    <= '0;
         base_q     <= '0;
         mode_q     <= AM_HOLD;
         win_q      <= '0;
         pos_q      <= '0;
         words_left <= '0;
      end else if (load) begin
         cur_off    <= ld_off;
         base_q     <= ld_off;
         mode_q     <= ld_mode;
         win_q      <= ld_win;
         pos_q      <= '0;
         words_left <= ld_cnt;
      end else if (step) begin
         words_left <= words_left - CNT_W'(1);
         unique case (mode_q)
            AM_STEP: cur_off <= cur_off + OFF_W'(4);
            AM_FOLD: begin
               if (pos_q == win_q - WIN_W'(1)) begin
                  cur_off <= base_q;
                  pos_q   <= '0;
               end else begin
                  cur_off <= cur_off + OFF_W'(4);
                  pos_q   <= pos_q + WIN_W'(1);
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/regdma_cmd_exec.sv
module regdma_cmd_exec
   import regdma_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] TGT_BASE   = 32'h4000_0000,
   parameter logic [ADDR_W-1:0] TGT_STRIDE = 32'h0010_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_last,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data,
   output logic              err_o
);

   localparam longint unsigned WIN_BYTES = 64'd1 << OFF_W;
   localparam longint unsigned SPAN =
      longint'(TGT_BASE) + longint'(NUM_TGT - 1) * longint'(TGT_STRIDE) + WIN_BYTES;
   localparam bit STRIDE_POW2 = ((TGT_STRIDE & (TGT_STRIDE - 1'b1)) == '0);

   // elaboration-time parameter checks
   if (ADDR_W <= OFF_W || ADDR_W > 63) begin : g_bad_width
      $error("ADDR_W must exceed the offset width and stay below 64");
   end
   if (longint'(TGT_STRIDE) < WIN_BYTES) begin : g_bad_stride
      $error("TGT_STRIDE smaller than one offset window");
   end
   if (ADDR_W <= 63 && SPAN > (64'd1 << ADDR_W)) begin : g_bad_span
      $error("target windows do not fit in ADDR_W");
   end

   // ---------------------------------------------------------------- state
   exec_state_e        state_q;
   cmd_kind_e          kind_q;
   logic [OFF_W-1:0]   off_q;
   logic [NUM_TGT-1:0] sel_q;
   logic               sel_ok_q;
   logic               buf_start_q;
   logic               last_seen_q;
   logic [WORD_W-1:0]  data_q;
   logic [TIDX_W-1:0]  cur_q;
   logic               err_q;

   // ---------------------------------------------------------------- decode
   cmd_kind_e          d_kind;
   logic [OFF_W-1:0]   d_off;
   logic               d_misal;
   logic [NUM_TGT-1:0] d_mask;
   logic               d_empty, d_mixed, d_win_bad, d_hold;
   logic [CNT_W-1:0]   d_cnt;
   logic [WIN_W-1:0]   d_win;

   regdma_hdr_dec u_dec (
      .word           (in_data),
      .kind           (d_kind),
      .offset         (d_off),
      .off_misaligned (d_misal),
      .tgt_mask       (d_mask),
      .mask_empty     (d_empty),
      .mask_mixed     (d_mixed),
      .count          (d_cnt),
      .window         (d_win),
      .window_bad     (d_win_bad),
      .hold_addr      (d_hold)
   );

   // ---------------------------------------------------------------- fan-out
   logic [TIDX_W-1:0] first_idx, next_idx;
   logic              has_next;

   regdma_tgt_walk #(.NT(NUM_TGT), .IW(TIDX_W)) u_walk (
      .mask      (sel_q),
      .cur       (cur_q),
      .first_idx (first_idx),
      .next_idx  (next_idx),
      .has_next  (has_next)
   );

   // ---------------------------------------------------------------- offsets
   logic              accept;
   logic              seq_load, seq_step;
   addr_mode_e        seq_mode;
   logic [CNT_W-1:0]  seq_cnt;
   logic [OFF_W-1:0]  seq_off;
   logic [CNT_W-1:0]  words_left;

   assign in_ready = (state_q == S_HDR0) || (state_q == S_HDR1) ||
                     (state_q == S_DATA) || (state_q == S_DROP);
   assign accept   = in_valid && in_ready;

   always_comb begin
      unique case (kind_q)
         K_STEP:  seq_mode = AM_STEP;
         K_TABLE: seq_mode = d_hold ? AM_HOLD : AM_FOLD;
         default: seq_mode = AM_HOLD;
      endcase
   end

   assign seq_cnt  = (kind_q == K_SINGLE) ? CNT_W'(1) : d_cnt;
   assign seq_load = (state_q == S_HDR1) && accept && (kind_q != K_SELECT);
   assign seq_step = (state_q == S_EMIT) && wr_ready && !has_next;

   regdma_addr_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (seq_load),
      .ld_off     (off_q),
      .ld_mode    (seq_mode),
      .ld_win     (d_win),
      .ld_cnt     (seq_cnt),
      .step       (seq_step),
      .cur_off    (seq_off),
      .words_left (words_left)
   );

   // ---------------------------------------------------------------- address
   logic [ADDR_W-1:0] tgt_base;

   if (STRIDE_POW2) begin : g_shift_base
      assign tgt_base = TGT_BASE + (ADDR_W'(cur_q) << $clog2(TGT_STRIDE));
   end else begin : g_mul_base
      assign tgt_base = TGT_BASE + ADDR_W'(cur_q) * TGT_STRIDE;
   end

   assign wr_valid = (state_q == S_EMIT);
   assign wr_addr  = tgt_base + ADDR_W'(seq_off);
   assign wr_data  = data_q;
   assign err_o    = err_q;

   // ---------------------------------------------------------------- control
   logic hdr0_bad, hdr1_bad, burst_kind;

   assign hdr0_bad = (d_kind == K_BAD) ||
                     ((d_kind != K_SELECT) && (!sel_ok_q || d_misal));
   assign burst_kind = (kind_q == K_STEP) || (kind_q == K_FIXED) ||
                       (kind_q == K_TABLE);
   assign hdr1_bad = ((kind_q == K_SELECT) && (d_empty || d_mixed)) ||
                     ((kind_q == K_TABLE) && d_win_bad);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= S_HDR0;
         kind_q      <= K_BAD;
         off_q       <= '0;
         sel_q       <= '0;
         sel_ok_q    <= 1'b0;
         buf_start_q <= 1'b1;
         last_seen_q <= 1'b0;
         data_q      <= '0;
         cur_q       <= '0;
         err_q       <= 1'b0;
      end else begin
         unique case (state_q)
            S_HDR0: if (accept) begin
               buf_start_q <= 1'b0;
               if (buf_start_q) err_q <= 1'b0;
               if (hdr0_bad || in_last) begin
                  err_q <= 1'b1;
                  if (in_last) begin
                     sel_ok_q    <= 1'b0;
                     buf_start_q <= 1'b1;
                  end else begin
                     state_q <= S_DROP;
                  end
               end else begin
                  kind_q  <= d_kind;
                  off_q   <= d_off;
                  state_q <= S_HDR1;
               end
            end

            S_HDR1: if (accept) begin
               if (hdr1_bad || (burst_kind && in_last && d_cnt != '0)) begin
                  err_q <= 1'b1;
                  if (in_last) begin
                     sel_ok_q    <= 1'b0;
                     buf_start_q <= 1'b1;
                     state_q     <= S_HDR0;
                  end else begin
                     state_q <= S_DROP;
                  end
               end else if (kind_q == K_SELECT) begin
                  sel_q    <= d_mask;
                  sel_ok_q <= !in_last;
                  if (in_last) buf_start_q <= 1'b1;
                  state_q  <= S_HDR0;
               end else if (kind_q == K_SINGLE) begin
                  data_q      <= in_data;
                  cur_q       <= first_idx;
                  last_seen_q <= in_last;
                  state_q     <= S_EMIT;
               end else if (d_cnt == '0) begin
                  if (in_last) begin
                     sel_ok_q    <= 1'b0;
                     buf_start_q <= 1'b1;
                  end
                  state_q <= S_HDR0;
               end else begin
                  state_q <= S_DATA;
               end
            end

            S_DATA: if (accept) begin
               if (in_last && words_left != CNT_W'(1)) begin
                  err_q       <= 1'b1;
                  sel_ok_q    <= 1'b0;
                  buf_start_q <= 1'b1;
                  state_q     <= S_HDR0;
               end else begin
                  data_q      <= in_data;
                  cur_q       <= first_idx;
                  last_seen_q <= in_last;
                  state_q     <= S_EMIT;
               end
            end

            S_EMIT: if (wr_ready) begin
               if (has_next) begin
                  cur_q <= next_idx;
               end else if (words_left == CNT_W'(1)) begin
                  state_q <= S_HDR0;
                  if (last_seen_q) begin
                     sel_ok_q    <= 1'b0;
                     buf_start_q <= 1'b1;
                     last_seen_q <= 1'b0;
                  end
               end else begin
                  state_q <= S_DATA;
               end
            end

            S_DROP: if (accept && in_last) begin
               sel_ok_q    <= 1'b0;
               buf_start_q <= 1'b1;
               state_q     <= S_HDR0;
            end

            default: state_q <= S_HDR0;
         endcase
      end
   end

endmodule

// File: rtl/regdma_cmd_exec_chk.sv
module regdma_cmd_exec_chk #(
   parameter int                ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] TGT_BASE   = 32'h4000_0000,
   parameter logic [ADDR_W-1:0] TGT_STRIDE = 32'h0010_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [31:0]       wr_data,
   input logic              err_o
);

   localparam longint unsigned TOP_ADDR =
      longint'(TGT_BASE) + 64'd10 * longint'(TGT_STRIDE);

   // R13
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

   // R14
   in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !in_ready);

   // R12
   err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> $past(in_valid && in_ready));

   // R12
   err_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_o) |-> $past(in_valid && in_ready));

   // R2
   addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (longint'(wr_addr) >= longint'(TGT_BASE)) &&
                   (longint'(wr_addr) < TOP_ADDR));

endmodule

bind regdma_cmd_exec regdma_cmd_exec_chk #(
   .ADDR_W     (ADDR_W),
   .TGT_BASE   (TGT_BASE),
   .TGT_STRIDE (TGT_STRIDE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .wr_valid (wr_valid),
   .wr_ready (wr_ready),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .err_o    (err_o)
);

// File: tb/test_regdma_cmd_exec.sv
module test_regdma_cmd_exec;

   localparam int             AW     = 28;
   localparam logic [AW-1:0]  BASE   = 28'h080_0000;
   localparam logic [AW-1:0]  STRIDE = 28'h018_0000;
   localparam logic [31:0]    SELW   = 32'h180A_C060;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_last = 1'b0, wr_ready = 1'b1;
   logic [31:0] in_data = '0;
   logic in_ready, wr_valid, err_o;
   logic [AW-1:0] wr_addr;
   logic [31:0] wr_data;

   always #5 clk = ~clk;

   regdma_cmd_exec #(.ADDR_W(AW), .TGT_BASE(BASE), .TGT_STRIDE(STRIDE)) i_regdma_cmd_exec (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_last(in_last), .wr_valid(wr_valid),
      .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .err_o(err_o)
   );

   int total = 0, bad = 0;
   bit stall_en = 0;
   logic [31:0]   stim[$];
   logic [AW-1:0] ea[$], oa[$];
   logic [31:0]   ed[$], od[$];

   // monitor away from the active edge
   initial forever begin
      @(negedge clk);
      if (rst_n && wr_valid && wr_ready) begin
         oa.push_back(wr_addr);
         od.push_back(wr_data);
      end
   end

   // write-side back-pressure
   initial begin
      logic [7:0] lf = 8'h5B;
      forever begin
         @(posedge clk); #1;
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         wr_ready = stall_en ? lf[0] : 1'b1;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic int mask_pos(input int k);
      if (k < 5) return k;
      if (k < 9) return 17 + (k - 5);
      return 21;
   endfunction

   function automatic logic [31:0] hdr(input logic [3:0] op, input logic [19:0] off);
      return {op, 8'h00, off};
   endfunction

   function automatic logic [31:0] tw(input bit hold, input logic [3:0] win,
                                      input logic [13:0] cnt);
      return {hold, 11'h0, win, 2'b00, cnt};
   endfunction

   task automatic expect_wr(input logic [31:0] mask, input logic [19:0] off,
                            input logic [31:0] d);
      for (int k = 0; k < 10; k++)
         if (mask[mask_pos(k)]) begin
            ea.push_back(BASE + AW'(k) * STRIDE + AW'(off));
            ed.push_back(d);
         end
   endtask

   task automatic run_buf();
      for (int i = 0; i < stim.size(); i++) begin
         @(posedge clk); #1;
         in_valid = 1'b1;
         in_data  = stim[i];
         in_last  = (i == stim.size() - 1);
         do @(negedge clk); while (!in_ready);
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_last  = 1'b0;
      @(negedge clk);
      while (wr_valid) @(negedge clk);
      stim.delete();
   endtask

   task automatic check_writes(input string req);
      chk(req, "write count", 64'(oa.size()), 64'(ea.size()));
      for (int i = 0; i < oa.size() && i < ea.size(); i++) begin
         chk(req, $sformatf("addr[%0d]", i), 64'(oa[i]), 64'(ea[i]));
         chk(req, $sformatf("data[%0d]", i), 64'(od[i]), 64'(ed[i]));
      end
      oa.delete(); od.delete(); ea.delete(); ed.delete();
   endtask

   // ------------------------------------------------------------ scenarios
   task automatic t_reset();
      @(negedge clk);
      chk("R14", "in_ready after reset", 64'(in_ready), 64'd1);
      chk("R14", "wr_valid after reset", 64'(wr_valid), 64'd0);
      chk("R14", "err after reset", 64'(err_o), 64'd0);
   endtask

   task automatic t_single();
      stim = '{SELW, 32'h0000_0004, hdr(4'b0001, 20'h00100), 32'hA5A5_0001};
      expect_wr(32'h4, 20'h00100, 32'hA5A5_0001);
      run_buf();
      check_writes("R3");
      chk("R1", "no error", 64'(err_o), 64'd0);
   endtask

   task automatic t_step_fanout();
      logic [31:0] m = (32'h1 << 17) | (32'h1 << 19) | (32'h1 << 21);
      stall_en = 1;
      stim = '{SELW, m, hdr(4'b0100, 20'h00040), 32'd3, 32'hD0, 32'hD1, 32'hD2};
      for (int w = 0; w < 3; w++) expect_wr(m, 20'h00040 + 20'(4 * w), 32'hD0 + 32'(w));
      run_buf();
      stall_en = 0;
      check_writes("R2 R4 R13");
   endtask

   task automatic t_fixed_burst();
      stim = '{SELW, 32'h10, hdr(4'b0011, 20'h00200), 32'd4,
               32'h11, 32'h22, 32'h33, 32'h44};
      for (int w = 0; w < 4; w++) expect_wr(32'h10, 20'h00200, 32'h11 * 32'(w + 1));
      run_buf();
      check_writes("R5");
   endtask

   task automatic t_table();
      stim = '{SELW, 32'h1, hdr(4'b0101, 20'h00010), tw(0, 4'd3, 14'd7)};
      for (int w = 0; w < 7; w++) begin
         stim.push_back(32'h700 + 32'(w));
         expect_wr(32'h1, 20'h00010 + 20'(4 * (w % 3)), 32'h700 + 32'(w));
      end
      stim.push_back(hdr(4'b0101, 20'h00030));
      stim.push_back(tw(1, 4'd2, 14'd3));
      for (int w = 0; w < 3; w++) begin
         stim.push_back(32'h900 + 32'(w));
         expect_wr(32'h1, 20'h00030, 32'h900 + 32'(w));
      end
      run_buf();
      check_writes("R6");
   endtask

   task automatic t_zero_count();
      stim = '{SELW, 32'h2, hdr(4'b0100, 20'h00080), 32'd0,
               hdr(4'b0001, 20'h00084), 32'hBEEF};
      expect_wr(32'h2, 20'h00084, 32'hBEEF);
      run_buf();
      check_writes("R7");
      chk("R7", "no error", 64'(err_o), 64'd0);
   endtask

   task automatic t_no_select();
      stim = '{hdr(4'b0001, 20'h00100), 32'h1, SELW, 32'h1,
               hdr(4'b0001, 20'h00004), 32'h2};
      run_buf();
      check_writes("R8 R12");
      chk("R8", "error after write without select", 64'(err_o), 64'd1);
      stim = '{SELW, 32'h8, hdr(4'b0001, 20'h0000C), 32'hC0DE};
      expect_wr(32'h8, 20'h0000C, 32'hC0DE);
      run_buf();
      check_writes("R12");
      chk("R12", "error cleared by next buffer", 64'(err_o), 64'd0);
   endtask

   task automatic t_no_carry();
      stim = '{SELW, 32'h8, hdr(4'b0001, 20'h00020), 32'h55};
      expect_wr(32'h8, 20'h00020, 32'h55);
      run_buf();
      stim = '{hdr(4'b0001, 20'h00024), 32'h66};
      run_buf();
      check_writes("R8");
      chk("R8", "selection not carried", 64'(err_o), 64'd1);
   endtask

   task automatic t_bad_masks();
      stim = '{SELW, 32'h1 | (32'h1 << 18), hdr(4'b0001, 20'h0), 32'h1};
      run_buf();
      check_writes("R9");
      chk("R9", "mixed groups error", 64'(err_o), 64'd1);
      stim = '{SELW, 32'h20, hdr(4'b0001, 20'h0), 32'h1};
      run_buf();
      check_writes("R9");
      chk("R9", "empty mask error", 64'(err_o), 64'd1);
      stim = '{SELW, 32'h1 | 32'h20 | (32'h1 << 30), hdr(4'b0001, 20'h00008), 32'h77};
      expect_wr(32'h1, 20'h00008, 32'h77);
      run_buf();
      check_writes("R1");
      chk("R1", "ignored bits no error", 64'(err_o), 64'd0);
   endtask

   task automatic t_bad_headers();
      stim = '{SELW, 32'h1, 32'h2000_0000, 32'h0, hdr(4'b0001, 20'h0), 32'h1};
      run_buf();
      check_writes("R10");
      chk("R10", "unknown code error", 64'(err_o), 64'd1);
      stim = '{SELW, 32'h1, hdr(4'b0001, 20'h00102), 32'h1};
      run_buf();
      check_writes("R10");
      chk("R10", "misaligned offset error", 64'(err_o), 64'd1);
      stim = '{SELW, 32'h1, 32'h1100_0010, 32'h1};
      run_buf();
      check_writes("R10");
      chk("R10", "nonzero bits 27:20 error", 64'(err_o), 64'd1);
      stim = '{SELW, 32'h1, hdr(4'b0101, 20'h0), tw(0, 4'd1, 14'd2), 32'h1, 32'h2};
      run_buf();
      check_writes("R6");
      chk("R6", "window below 2 error", 64'(err_o), 64'd1);
   endtask

   task automatic t_truncated();
      stim = '{SELW, 32'h2, hdr(4'b0100, 20'h00040), 32'd4, 32'hE0, 32'hE1};
      expect_wr(32'h2, 20'h00040, 32'hE0);
      run_buf();
      check_writes("R11");
      chk("R11", "short payload error", 64'(err_o), 64'd1);
      stim = '{SELW, 32'h2, hdr(4'b0001, 20'h0)};
      run_buf();
      check_writes("R11");
      chk("R11", "cut header error", 64'(err_o), 64'd1);
   endtask

   // ------------------------------------------------------------ sequence
   bit finished = 0;

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_single();
      t_step_fanout();
      t_fixed_burst();
      t_table();
      t_zero_count();
      t_no_select();
      t_no_carry();
      t_bad_masks();
      t_bad_headers();
      t_truncated();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule